// File: doc/BRIEF.md
# Card Clock Generator

This block derives the clock sent to a memory card from the controller's kernel clock. A 10-bit divide field selects the rate: a nonzero value N gives a card clock with a period of 2N kernel cycles and an even duty cycle, and zero sends the kernel clock straight through. The block also produces a one-cycle launch strobe. The command and data output registers use this strobe to change their outputs on the selected card-clock edge.

Two conditions stop the card clock, and it always stops low. The first is power saving while no transfer is in progress. The second is hardware flow control, which halts the clock during a write when the transmit FIFO runs dry, or during a read when the receive FIFO fills. The block also decodes the two bus-width bits into a lane-enable mask for the data pins.

Top module: `cardclk_gen`

## Requirements
- R1: With a nonzero divide value N and the clock running, `card_clk` is high for exactly N kernel cycles and low for exactly N kernel cycles.
- R2: With a divide value of 0, `card_clk` follows the kernel clock while running, and `launch_stb` stays high in every running cycle (launch on each falling kernel edge), whatever `cfg_negedge` holds.
- R3: With a nonzero divide value and `cfg_negedge` = 0, `launch_stb` is high in exactly those kernel cycles after which `card_clk` rises.
- R4: With a nonzero divide value and `cfg_negedge` = 1, `launch_stb` is high in exactly those kernel cycles after which `card_clk` falls.
- R5: A new divide value takes effect only where `card_clk` falls. Every high or low phase lasts either the old or the new N, and is never cut short or stretched by a count already in progress.
- R6: With `cfg_pwrsave` = 1 and `xfer_busy` = 0, `card_clk` is held low and `launch_stb` stays low, in both divided and bypass modes. With `xfer_busy` = 1 the clock runs.
- R7: With `cfg_flowctl` = 1 and `xfer_busy` = 1, the clock stops low while `xfer_write` = 1 and `txf_empty` = 1, or while `xfer_write` = 0 and `rxf_full` = 1. `txf_empty` has no effect during a read. With `cfg_flowctl` = 0, neither FIFO flag has any effect.
- R8: `lane_en` is 8'h01 when neither width bit is set, 8'h0F when only `cfg_wide4` is set, and 8'hFF when `cfg_wide8` is set, whether or not `cfg_wide4` is also set.
- R9: While `rst_n` is low, `card_clk` and `launch_stb` are low.
- R10: The largest divide value, 1023, gives high and low phases of 1023 kernel cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ker | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Divide value N (0 = bypass) |
| cfg_negedge | input | 1 | Launch on the falling card-clock edge when dividing |
| cfg_wide4 | input | 1 | Request 4 data lanes |
| cfg_wide8 | input | 1 | Request 8 data lanes (has priority) |
| cfg_pwrsave | input | 1 | Stop the clock when no transfer is active |
| cfg_flowctl | input | 1 | Enable FIFO-driven clock stop |
| xfer_busy | input | 1 | A command or data transfer is active |
| xfer_write | input | 1 | Transfer direction: 1 = write, 0 = read |
| txf_empty | input | 1 | Transmit FIFO is empty |
| rxf_full | input | 1 | Receive FIFO is full |
| card_clk | output | 1 | Clock to the card |
| launch_stb | output | 1 | Output registers launch at the selected edge |
| lane_en | output | LANES | Enable mask for the data lanes |

## Verification
The bench builds the block with its default parameters: a 10-bit divide field and 8 lanes. These values put the full lane mask and the largest ratio of 1023 within reach. Phases of 1023 cycles fit easily in the run, so the top of the divide range is measured directly instead of being inferred from small values. Random divide values from 1 to 12 exercise the N = 1 case, where the clock toggles every kernel cycle and the launch strobe must alternate. The divide-change cases switch from a long ratio to a short one partway through a phase, which shows any load that is not deferred to the falling edge.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

   typedef enum logic [1:0] {
      BW_ONE   = 2'd0,
      BW_FOUR  = 2'd1,
      BW_EIGHT = 2'd2
   } bus_width_e;

   // eight-lane request wins when both requests are present
   function automatic bus_width_e pick_width(input logic want4, input logic want8);
      if (want8)      return BW_EIGHT;
      else if (want4) return BW_FOUR;
      else            return BW_ONE;
   endfunction

   function automatic int lanes_of(input bus_width_e w);
      case (w)
         BW_EIGHT: return 8;
         BW_FOUR:  return 4;
         default:  return 1;
      endcase
   endfunction

endpackage

// File: rtl/cardclk_run_ctl.sv
module cardclk_run_ctl (
   input  logic cfg_pwrsave,
   input  logic cfg_flowctl,
   input  logic xfer_busy,
   input  logic xfer_write,
   input  logic txf_empty,
   input  logic rxf_full,
   output logic run
);
   logic idle_stop;
   logic fifo_stop;

   always_comb begin
      idle_stop = cfg_pwrsave && !xfer_busy;
      fifo_stop = cfg_flowctl && xfer_busy &&
                  (xfer_write ? txf_empty : rxf_full);
      run       = !(idle_stop || fifo_stop);
   end
endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider #(
   parameter int DIV_W = 10
) (
   input  logic             clk_ker,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_negedge,
   input  logic             run,
   output logic             ck_q,
   output logic             byp_mode,
   output logic             div_launch
);
   localparam logic [DIV_W-1:0] ZERO = '0;
   localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);

   logic [DIV_W-1:0] div_act;
   logic [DIV_W-1:0] cnt;
   logic             at_end;
   logic             advance;
   logic             toggle;

   always_comb begin
      byp_mode = (div_act == ZERO);
      at_end   = (cnt == (div_act - ONE));
      // a high phase always completes, so the clock can only rest low
      advance  = run || ck_q;
      toggle   = !byp_mode && advance && at_end;
      div_launch = toggle && (cfg_negedge ? ck_q : !ck_q);
   end

   always_ff @(posedge clk_ker or negedge rst_n) begin
      if (!rst_n) begin
         div_act <= ZERO;
         cnt     <= ZERO;
         ck_q    <= 1'b0;
      end else if (byp_mode) begin
         div_act <= cfg_div;
         cnt     <= ZERO;
         ck_q    <= 1'b0;
      end else if (toggle) begin
         cnt  <= ZERO;
         ck_q <= !ck_q;
         if (ck_q) div_act <= cfg_div;
      end else if (!ck_q && !run) begin
         div_act <= cfg_div;
         cnt     <= ZERO;
      end else begin
         cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/cardclk_bypass_gate.sv
module cardclk_bypass_gate #(
   parameter int DIV_W = 10
) (
   input  logic             clk_ker,
   input  logic             rst_n,
   input  logic             run,
   input  logic             byp_mode,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             byp_en
);
   localparam logic [DIV_W-1:0] ZERO = '0;

   // updated while the kernel clock is low so the gated pulse is never cut
   always_ff @(negedge clk_ker or negedge rst_n) begin
      if (!rst_n) byp_en <= 1'b0;
      else        byp_en <= run && byp_mode && (cfg_div == ZERO);
   end
endmodule

// File: rtl/cardclk_lane_dec.sv
module cardclk_lane_dec #(
   parameter int LANES = 8
) (
   input  logic             cfg_wide4,
   input  logic             cfg_wide8,
   output logic [LANES-1:0] lane_en
);
   import cardclk_pkg::*;

   bus_width_e req;
   always_comb req = pick_width(cfg_wide4, cfg_wide8);

   generate
      if (LANES == 1) begin : g_one
         always_comb lane_en = 1'b1;
      end else if (LANES == 4) begin : g_four
         always_comb lane_en = (req == BW_ONE) ? 4'h1 : 4'hF;
      end else begin : g_eight
         always_comb begin
            lane_en = '0;
            for (int i = 0; i < LANES; i++)
               lane_en[i] = (i < lanes_of(req));
         end
      end
   endgenerate
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen #(
   parameter int DIV_W = 10,
   parameter int LANES = 8
) (
   input  logic             clk_ker,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_negedge,
   input  logic             cfg_wide4,
   input  logic             cfg_wide8,
   input  logic             cfg_pwrsave,
   input  logic             cfg_flowctl,
   input  logic             xfer_busy,
   input  logic             xfer_write,
   input  logic             txf_empty,
   input  logic             rxf_full,
   output logic             card_clk,
   output logic             launch_stb,
   output logic [LANES-1:0] lane_en
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("cardclk_gen: DIV_W must lie in 1..16");
      end
      if (LANES != 1 && LANES != 4 && LANES != 8) begin : g_bad_lanes
         $error("cardclk_gen: LANES must be 1, 4 or 8");
      end
   endgenerate

   logic run;
   logic ck_q;
   logic byp_mode;
   logic div_launch;
   logic byp_en;

   cardclk_run_ctl u_run (
      .cfg_pwrsave (cfg_pwrsave),
      .cfg_flowctl (cfg_flowctl),
      .xfer_busy   (xfer_busy),
      .xfer_write  (xfer_write),
      .txf_empty   (txf_empty),
      .rxf_full    (rxf_full),
      .run         (run)
   );

   cardclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk_ker     (clk_ker),
      .rst_n       (rst_n),
      .cfg_div     (cfg_div),
      .cfg_negedge (cfg_negedge),
      .run         (run),
      .ck_q        (ck_q),
      .byp_mode    (byp_mode),
      .div_launch  (div_launch)
   );

   cardclk_bypass_gate #(.DIV_W(DIV_W)) u_byp (
      .clk_ker  (clk_ker),
      .rst_n    (rst_n),
      .run      (run),
      .byp_mode (byp_mode),
      .cfg_div  (cfg_div),
      .byp_en   (byp_en)
   );

   cardclk_lane_dec #(.LANES(LANES)) u_lanes (
      .cfg_wide4 (cfg_wide4),
      .cfg_wide8 (cfg_wide8),
      .lane_en   (lane_en)
   );

   always_comb begin
      card_clk   = (clk_ker & byp_en) | ck_q;
      launch_stb = byp_mode ? byp_en : div_launch;
   end
endmodule

// File: rtl/cardclk_gen_chk.sv
module cardclk_gen_chk #(
   parameter int LANES = 8
) (
   input logic             clk_ker,
   input logic             rst_n,
   input logic             cfg_negedge,
   input logic             cfg_wide4,
   input logic             cfg_wide8,
   input logic             cfg_pwrsave,
   input logic             cfg_flowctl,
   input logic             xfer_busy,
   input logic             xfer_write,
   input logic             txf_empty,
   input logic             rxf_full,
   input logic             card_clk,
   input logic             launch_stb,
   input logic [LANES-1:0] lane_en,
   input logic             byp_mode
);
   localparam logic [LANES-1:0] ALL_LANES = '1;
   localparam logic [LANES-1:0] ONE_LANE  = LANES'(1);

   logic stop_req;
   always_comb
      stop_req = (cfg_pwrsave && !xfer_busy) ||
                 (cfg_flowctl && xfer_busy && (xfer_write ? txf_empty : rxf_full));

   // R3: rising launch is announced while low and followed by a high clock
   a_r3_launch_low: assert property (@(posedge clk_ker) disable iff (!rst_n)
      (launch_stb && !byp_mode && !cfg_negedge) |-> !card_clk);
   a_r3_launch_rise: assert property (@(posedge clk_ker) disable iff (!rst_n)
      (launch_stb && !byp_mode && !cfg_negedge) |=> card_clk);

   // R4: falling launch is followed by a low clock
   a_r4_launch_fall: assert property (@(posedge clk_ker) disable iff (!rst_n)
      (launch_stb && !byp_mode && cfg_negedge) |=> !card_clk);

   // R6 / R7: a stopped clock rests low
   a_r7_stop_low: assert property (@(posedge clk_ker) disable iff (!rst_n)
      (stop_req && !card_clk && !byp_mode) |=> !card_clk);

   // R8: lane decode
   a_r8_wide: assert property (@(posedge clk_ker) disable iff (!rst_n)
      cfg_wide8 |-> (lane_en == ALL_LANES));
   a_r8_single: assert property (@(posedge clk_ker) disable iff (!rst_n)
      (!cfg_wide4 && !cfg_wide8) |-> (lane_en == ONE_LANE));

   // R9: quiet outputs during reset
   always @(negedge clk_ker) begin
      if (!rst_n) begin
         a_r9_reset_quiet: assert (!card_clk && !launch_stb);
      end
   end
endmodule

bind cardclk_gen cardclk_gen_chk #(.LANES(LANES)) i_chk (
   .clk_ker     (clk_ker),
   .rst_n       (rst_n),
   .cfg_negedge (cfg_negedge),
   .cfg_wide4   (cfg_wide4),
   .cfg_wide8   (cfg_wide8),
   .cfg_pwrsave (cfg_pwrsave),
   .cfg_flowctl (cfg_flowctl),
   .xfer_busy   (xfer_busy),
   .xfer_write  (xfer_write),
   .txf_empty   (txf_empty),
   .rxf_full    (rxf_full),
   .card_clk    (card_clk),
   .launch_stb  (launch_stb),
   .lane_en     (lane_en),
   .byp_mode    (byp_mode)
);

// File: tb/test_cardclk_gen.sv
`timescale 1ns/1ps
module test_cardclk_gen;
   localparam int DIV_W = 10;
   localparam int LANES = 8;

   logic             clk_ker = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic             cfg_negedge = 1'b0;
   logic             cfg_wide4 = 1'b0;
   logic             cfg_wide8 = 1'b0;
   logic             cfg_pwrsave = 1'b0;
   logic             cfg_flowctl = 1'b0;
   logic             xfer_busy = 1'b0;
   logic             xfer_write = 1'b0;
   logic             txf_empty = 1'b0;
   logic             rxf_full = 1'b0;
   logic             card_clk;
   logic             launch_stb;
   logic [LANES-1:0] lane_en;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #2.5 clk_ker = ~clk_ker;

   cardclk_gen #(.DIV_W(DIV_W), .LANES(LANES)) i_cardclk_gen (.*);

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_lanes(input bit w4, input bit w8);
      if (w8) return 'hFF;
      if (w4) return 'h0F;
      return 'h01;
   endfunction

   task automatic drive(input int n, input bit neg);
      @(posedge clk_ker); #2;
      cfg_div = DIV_W'(n);
      cfg_negedge = neg;
   endtask

   task automatic set_ctl(input bit ps, input bit fc, input bit busy,
                          input bit wr, input bit te, input bit rf);
      @(posedge clk_ker); #2;
      cfg_pwrsave = ps; cfg_flowctl = fc; xfer_busy = busy;
      xfer_write = wr; txf_empty = te; rxf_full = rf;
   endtask

   // phase lengths must be na or nb; launch must precede the chosen edge
   task automatic measure_div(input int na, input int nb, input bit neg,
                              input int settle, input int win,
                              input string req_p, input string req_l);
      int  runlen;
      int  bad_p;
      int  bad_l;
      int  edges;
      int  worst;
      bit  seen;
      bit  pck;
      bit  pln;
      runlen = 0; bad_p = 0; bad_l = 0; edges = 0; seen = 0; pck = 0; pln = 0;
      worst = na;
      repeat (settle) @(posedge clk_ker);
      for (int i = 0; i < win; i++) begin
         @(posedge clk_ker); #1;
         if (i > 0) begin
            bit edg;
            bit want;
            edg  = (card_clk != pck);
            want = edg && (card_clk == !neg);
            if (pln != want) bad_l++;
            if (edg) begin
               edges++;
               if (seen && runlen != na && runlen != nb) begin
                  bad_p++; worst = runlen;
               end
               seen = 1; runlen = 1;
            end else begin
               runlen++;
            end
         end
         pck = card_clk;
         pln = launch_stb;
      end
      check(bad_p == 0 && edges >= 2, req_p, "phase length", worst, na);
      check(bad_l == 0, req_l, "launch misplaced count", bad_l, 0);
   endtask

   task automatic expect_quiet(input int settle, input int win, input string req);
      int highs;
      highs = 0;
      repeat (settle) @(posedge clk_ker);
      for (int i = 0; i < win; i++) begin
         @(posedge clk_ker); #1;
         if (card_clk || launch_stb) highs++;
         @(negedge clk_ker); #1;
         if (card_clk) highs++;
      end
      check(highs == 0, req, "samples with clock or launch high", highs, 0);
   endtask

   task automatic measure_bypass(input int win, input string req);
      int bad;
      bad = 0;
      repeat (4) @(posedge clk_ker);
      for (int i = 0; i < win; i++) begin
         @(posedge clk_ker); #1;
         if (!card_clk || !launch_stb) bad++;
         @(negedge clk_ker); #1;
         if (card_clk) bad++;
      end
      check(bad == 0, req, "bypass mismatches", bad, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk_ker);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      cfg_div = DIV_W'(3);
      // R9: reset quiet
      repeat (3) begin
         @(posedge clk_ker); #1;
         check(!card_clk && !launch_stb, "R9", "reset high phase", int'(card_clk), 0);
         @(negedge clk_ker); #1;
         check(!card_clk, "R9", "reset low phase", int'(card_clk), 0);
      end
      @(posedge clk_ker); #2;
      rst_n = 1'b1;

      // R8: lane decode, all four combinations
      for (int k = 0; k < 4; k++) begin
         @(posedge clk_ker); #2;
         cfg_wide4 = k[0]; cfg_wide8 = k[1];
         #1;
         check(int'(lane_en) == exp_lanes(k[0], k[1]), "R8", "lane mask",
               int'(lane_en), exp_lanes(k[0], k[1]));
      end

      // R1, R3: directed N = 3 rising launch
      drive(3, 0);
      measure_div(3, 3, 0, 20, 40, "R1", "R3");
      // R4: falling launch
      drive(3, 1);
      measure_div(3, 3, 1, 20, 40, "R1", "R4");
      // N = 1 boundary
      drive(1, 0);
      measure_div(1, 1, 0, 10, 30, "R1", "R3");

      // R2: bypass, with either launch-edge setting
      drive(0, 0);
      measure_bypass(20, "R2");
      drive(0, 1);
      measure_bypass(20, "R2");

      // R1, R3, R4: random ratios and edges
      for (int k = 0; k < 10; k++) begin
         int n;
         bit neg;
         n   = int'($urandom_range(1, 12));
         neg = bit'($urandom_range(0, 1));
         drive(n, neg);
         measure_div(n, n, neg, 4 * n + 8, 8 * n + 8, "R1", neg ? "R4" : "R3");
      end

      // R5: long to short ratio changed mid-high-phase
      drive(7, 0);
      repeat (40) @(posedge clk_ker);
      begin
         int guard;
         guard = 0;
         do begin @(posedge clk_ker); #1; guard++; end
         while (!card_clk && guard < 100);
      end
      repeat (4) @(posedge clk_ker);
      drive(3, 0);
      measure_div(7, 3, 0, 0, 60, "R5", "R3");
      measure_div(3, 3, 0, 4, 30, "R5", "R3");
      // short to long
      drive(9, 1);
      measure_div(3, 9, 1, 0, 60, "R5", "R4");

      // R10: largest ratio
      drive(1023, 0);
      measure_div(1023, 1023, 0, 2 * 2046 + 10, 4300, "R10", "R3");

      // R6: power save
      drive(2, 0);
      set_ctl(1, 0, 0, 0, 0, 0);
      expect_quiet(8, 20, "R6");
      set_ctl(1, 0, 1, 0, 0, 0);
      measure_div(2, 2, 0, 8, 20, "R6", "R3");
      drive(0, 0);
      set_ctl(1, 0, 0, 0, 0, 0);
      expect_quiet(4, 20, "R6");
      set_ctl(1, 0, 1, 0, 0, 0);
      measure_bypass(10, "R6");

      // R7: flow control
      drive(2, 0);
      set_ctl(0, 1, 1, 1, 1, 0);
      expect_quiet(8, 20, "R7");
      set_ctl(0, 1, 1, 0, 1, 0);
      measure_div(2, 2, 0, 8, 20, "R7", "R3");
      set_ctl(0, 1, 1, 0, 0, 1);
      expect_quiet(8, 20, "R7");
      set_ctl(0, 0, 1, 1, 1, 1);
      measure_div(2, 2, 0, 8, 20, "R7", "R3");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule